// File: doc/BRIEF.md
# Pixel Component Unpacker

This block sits between a 16-bit host data path and a wavelet pipeline. It takes words that carry uncompressed tile samples, delivered in raster order from the upper-left corner of the tile, and turns them into a stream of single components. Each component is a 14-bit value together with a tag that says whether it is luminance, blue chroma or red chroma. The host programs a sample format, a component arrangement and the tile dimensions, then pulses `start`. From then on the block accepts words through a valid/ready handshake and emits components through a second valid/ready handshake.

A packed word carries two 8-bit components. The roles of those two bytes follow from the arrangement: luma with alternating chroma, a Cb/Cr pair, or two successive samples of one component. The component tag comes from a running sequence over the emitted stream, so packed and unpacked inputs of the same arrangement produce the same tag order.

A component counter compares the emitted total with the programmed tile size. It raises `done` once the last component has left the block. Any word that arrives after that point is accepted, thrown away and recorded as an overrun.

Top module: `pix_unpack`

## Requirements
- R1: After reset and until the first `start`, `in_ready`, `out_valid`, `done` and `overrun` are all 0, and input words are not accepted.
- R2: A `start` pulse captures `cfg_fmt`, `cfg_arr`, `cfg_width` and `cfg_height`, clears `done`, `overrun` and any held component, and raises `in_ready` in the following cycle.
- R3: With `cfg_fmt`=0 (10-bit), each word yields one component equal to bits 9:0, and bits 15:10 have no effect.
- R4: With `cfg_fmt`=1 (8-bit), each word yields one component equal to bits 7:0, and bits 15:8 have no effect.
- R5: With `cfg_fmt`=3 (raw), each word yields one component equal to bits 15:2, and bits 1:0 have no effect.
- R6: With `cfg_fmt`=2 (packed pair), each word yields two zero-extended components: bits 15:8 first, then bits 7:0.
- R7: The component tag (0=Y, 1=Cb, 2=Cr) follows the emitted component count from `start`. With `cfg_arr`=2 (three-component 4:2:2) it repeats Y, Cb, Y, Cr. With `cfg_arr`=1 (chroma only) it repeats Cb, Cr. With `cfg_arr`=0 (single component) it is always Y.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_comp` hold their values.
- R9: A tile holds `cfg_width`×`cfg_height` components for arrangements 0 and 1, and twice that for arrangement 2. `done` rises in the cycle after the last component handshake, and `out_valid` stays 0 while `done` is 1.
- R10: A word accepted after the last component of the tile has been emitted, including a word taken in the same cycle as that last handshake, produces no output. It sets `overrun` in the next cycle, and `overrun` stays set until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a tile and capture the configuration |
| cfg_fmt | input | 2 | Sample format: 0 10-bit, 1 8-bit, 2 packed pair, 3 raw 14-bit |
| cfg_arr | input | 2 | Arrangement: 0 single, 1 chroma only, 2 three-component 4:2:2 |
| cfg_width | input | DIM_W | Tile width in pixels |
| cfg_height | input | DIM_W | Tile height in rows |
| in_valid | input | 1 | Host word available |
| in_ready | output | 1 | Block accepts the host word |
| in_data | input | DATA_W | Host word |
| out_valid | output | 1 | Component available |
| out_ready | input | 1 | Downstream accepts the component |
| out_data | output | SAMP_W | Component value |
| out_comp | output | 2 | Component tag: 0 Y, 1 Cb, 2 Cr |
| done | output | 1 | All components of the tile have been emitted |
| overrun | output | 1 | Surplus input word seen since `start` |

## Verification
Each format is fed words whose ignored bits are filled with noise. A slicer that picked the wrong byte or a misaligned raw field would then show up as a wrong value on the first component. Packed tests in every arrangement check the byte order and the tag sequence, so a design that emitted the low byte first, or advanced the tag once per word instead of once per component, would produce a mismatching stream. Random and alternating back-pressure, plus a long forced stall, would expose a design that drops or changes a held component, or that takes a new word while the second half of a packed word is still waiting. Words sent after the tile ends, and the restart that follows, would show an off-by-one tile count, a non-sticky overrun flag, or a flag that `start` fails to clear.

// File: rtl/pix_unpack_pkg.sv
// Shared encodings for the pixel component unpacker.
// Assumes: configuration fields are 2 bits wide; tags fit in 2 bits.
package pix_unpack_pkg;

    localparam logic [1:0] FMT_TEN   = 2'd0;
    localparam logic [1:0] FMT_EIGHT = 2'd1;
    localparam logic [1:0] FMT_PAIR  = 2'd2;
    localparam logic [1:0] FMT_RAW   = 2'd3;

    localparam logic [1:0] ARR_MONO   = 2'd0;
    localparam logic [1:0] ARR_CHROMA = 2'd1;
    localparam logic [1:0] ARR_TRIPLE = 2'd2;

    localparam logic [1:0] COMP_Y  = 2'd0;
    localparam logic [1:0] COMP_CB = 2'd1;
    localparam logic [1:0] COMP_CR = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FULL = 2'd2
    } unpack_state_e;

endpackage

// File: rtl/pix_word_slicer.sv
// Splits one host word into at most two component values.
// Assumes: DATA_W >= SAMP_W >= 10; packed bytes are zero-extended.
module pix_word_slicer
    import pix_unpack_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SAMP_W = 14
) (
    input  logic [1:0]        fmt,
    input  logic [DATA_W-1:0] word,
    output logic [SAMP_W-1:0] first,
    output logic [SAMP_W-1:0] second,
    output logic              paired
);

    // Field selection by sample format.
    always_comb begin
        second = '0;
        paired = 1'b0;
        case (fmt)
            FMT_TEN:   first = SAMP_W'(word[9:0]);
            FMT_EIGHT: first = SAMP_W'(word[7:0]);
            FMT_PAIR: begin
                first  = SAMP_W'(word[15:8]);
                second = SAMP_W'(word[7:0]);
                paired = 1'b1;
            end
            default:   first = word[DATA_W-1 -: SAMP_W];
        endcase
    end

endmodule

// File: rtl/pix_comp_seq.sv
// Produces the component tag for the next emitted component.
// Assumes: advance pulses once per output handshake; clear on tile start.
module pix_comp_seq
    import pix_unpack_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       advance,
    input  logic [1:0] arr,
    output logic [1:0] comp
);

    logic [1:0] phase_q;

    // Phase counter over the four-slot interleave pattern.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) phase_q <= '0;
        else if (advance)    phase_q <= phase_q + 2'd1;
    end

    // Tag decode from arrangement and phase.
    always_comb begin
        case (arr)
            ARR_TRIPLE: comp = !phase_q[0] ? COMP_Y : (phase_q[1] ? COMP_CR : COMP_CB);
            ARR_CHROMA: comp = phase_q[0] ? COMP_CR : COMP_CB;
            default:    comp = COMP_Y;
        endcase
    end

endmodule

// File: rtl/pix_tile_counter.sv
// Counts emitted components against the programmed tile size.
// Assumes: width*height*2 fits in 2*DIM_W+1 bits; size is nonzero.
module pix_tile_counter #(
    parameter int DIM_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIM_W-1:0] width,
    input  logic [DIM_W-1:0] height,
    input  logic             double_rate,
    input  logic             step,
    output logic             last
);

    localparam int CNT_W = 2 * DIM_W + 1;

    logic [CNT_W-1:0] total_q;
    logic [CNT_W-1:0] count_q;

    // Capture the tile total at start and count emitted components.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total_q <= '0;
            count_q <= '0;
        end else if (load) begin
            total_q <= (CNT_W'(width) * CNT_W'(height)) << double_rate;
            count_q <= '0;
        end else if (step) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Last-component detect on the current handshake.
    assign last = step && (count_q == total_q - 1'b1);

endmodule

// File: rtl/pix_unpack.sv
// Pixel component unpacker top: host words in, tagged components out.
// Assumes: cfg_* are stable around start; tile size is even in packed mode.
module pix_unpack
    import pix_unpack_pkg::*;
#(
    parameter int DIM_W  = 9,
    parameter int DATA_W = 16,
    parameter int SAMP_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        cfg_fmt,
    input  logic [1:0]        cfg_arr,
    input  logic [DIM_W-1:0]  cfg_width,
    input  logic [DIM_W-1:0]  cfg_height,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [SAMP_W-1:0] out_data,
    output logic [1:0]        out_comp,
    output logic              done,
    output logic              overrun
);

    unpack_state_e     state_q;
    logic [1:0]        fmt_q;
    logic [1:0]        arr_q;
    logic [SAMP_W-1:0] slot0_q;
    logic [SAMP_W-1:0] slot1_q;
    logic [1:0]        pend_q;
    logic              ovr_q;

    logic [SAMP_W-1:0] cut_first;
    logic [SAMP_W-1:0] cut_second;
    logic              cut_paired;
    logic              take;
    logic              emit;
    logic              tile_last;

    pix_word_slicer #(.DATA_W(DATA_W), .SAMP_W(SAMP_W)) i_slicer (
        .fmt    (fmt_q),
        .word   (in_data),
        .first  (cut_first),
        .second (cut_second),
        .paired (cut_paired)
    );

    pix_comp_seq i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .advance (emit),
        .arr     (arr_q),
        .comp    (out_comp)
    );

    pix_tile_counter #(.DIM_W(DIM_W)) i_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (start),
        .width       (cfg_width),
        .height      (cfg_height),
        .double_rate (cfg_arr == ARR_TRIPLE),
        .step        (emit),
        .last        (tile_last)
    );

    // Input acceptance: room for a word, or draining surplus after the tile.
    always_comb begin
        case (state_q)
            ST_RUN:  in_ready = (pend_q == 2'd0) || (pend_q == 2'd1 && out_ready);
            ST_FULL: in_ready = 1'b1;
            default: in_ready = 1'b0;
        endcase
    end

    assign take      = in_valid && in_ready;
    assign out_valid = (state_q == ST_RUN) && (pend_q != 2'd0);
    assign emit      = out_valid && out_ready;
    assign out_data  = slot0_q;
    assign done      = (state_q == ST_FULL);
    assign overrun   = ovr_q;

    // Control state, configuration capture and holding slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fmt_q   <= FMT_TEN;
            arr_q   <= ARR_MONO;
            slot0_q <= '0;
            slot1_q <= '0;
            pend_q  <= '0;
            ovr_q   <= 1'b0;
        end else if (start) begin
            state_q <= ST_RUN;
            fmt_q   <= cfg_fmt;
            arr_q   <= cfg_arr;
            pend_q  <= '0;
            ovr_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_RUN: begin
                    if (tile_last) begin
                        state_q <= ST_FULL;
                        pend_q  <= '0;
                        if (take) ovr_q <= 1'b1;
                    end else if (take) begin
                        slot0_q <= cut_first;
                        slot1_q <= cut_second;
                        pend_q  <= cut_paired ? 2'd2 : 2'd1;
                    end else if (emit) begin
                        slot0_q <= slot1_q;
                        pend_q  <= pend_q - 2'd1;
                    end
                end
                ST_FULL: begin
                    if (take) ovr_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pix_unpack_chk.sv
// Property checker for pix_unpack, attached by bind below.
// Assumes: sees the captured arrangement register of the top.
module pix_unpack_chk
    import pix_unpack_pkg::*;
#(
    parameter int SAMP_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              out_valid,
    input logic              out_ready,
    input logic [SAMP_W-1:0] out_data,
    input logic [1:0]        out_comp,
    input logic              done,
    input logic              overrun,
    input logic [1:0]        arr_q
);

    // R8: a stalled component is held unchanged.
    a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !start |=> out_valid && $stable(out_data) && $stable(out_comp));

    // R9: nothing is offered once the tile is complete.
    a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);

    // R10: overrun persists until the next start.
    a_r10_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !start |=> overrun);

    // R7: single-component tiles carry only the luma tag.
    a_r7_mono_tag: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && arr_q == ARR_MONO |-> out_comp == COMP_Y);

    // R7: the unused tag code never appears.
    a_r7_tag_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_comp != 2'd3);

    // R2: start clears completion, overrun and held data.
    a_r2_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done && !overrun && !out_valid);

endmodule

bind pix_unpack pix_unpack_chk #(.SAMP_W(SAMP_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_comp  (out_comp),
    .done      (done),
    .overrun   (overrun),
    .arr_q     (arr_q)
);

// File: tb/test_pix_unpack.sv
// Self-checking bench for pix_unpack with a behavioural queue model.
module test_pix_unpack;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  cfg_fmt = 2'd0;
    logic [1:0]  cfg_arr = 2'd0;
    logic [8:0]  cfg_width = 9'd8;
    logic [8:0]  cfg_height = 9'd8;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = 16'h0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [13:0] out_data;
    logic [1:0]  out_comp;
    logic        done;
    logic        overrun;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int rdy_mode = 0;
    bit mon_en = 1'b0;

    int qd[$];
    int qc[$];
    int mtotal = 0;
    int mcount = 0;
    int mpushed = 0;
    bit mdone = 1'b0;
    bit movr = 1'b0;

    always #10 clk = ~clk;

    pix_unpack i_pix_unpack (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_fmt(cfg_fmt), .cfg_arr(cfg_arr),
        .cfg_width(cfg_width), .cfg_height(cfg_height),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_comp(out_comp),
        .done(done), .overrun(overrun)
    );

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int slot_val(int fmt, logic [15:0] w, int s);
        case (fmt)
            0: return int'(w[9:0]);
            1: return int'(w[7:0]);
            2: return (s == 0) ? int'(w[15:8]) : int'(w[7:0]);
            default: return int'(w[15:2]);
        endcase
    endfunction

    function automatic int tag_of(int arr, int k);
        if (arr == 2) begin
            case (k % 4)
                1: return 1;
                3: return 2;
                default: return 0;
            endcase
        end
        if (arr == 1) return (k % 2 == 0) ? 1 : 2;
        return 0;
    endfunction

    // Reference model, compared on every falling edge.
    always @(negedge clk) begin
        if (mon_en && rst_n) begin
            check(done == mdone, "R9 done", int'(done), int'(mdone));
            check(overrun == movr, "R10 overrun", int'(overrun), int'(movr));
            check(out_valid == (qd.size() != 0), "R8 out_valid", int'(out_valid), int'(qd.size() != 0));
            if (out_valid && out_ready && qd.size() != 0) begin
                int ed;
                int ec;
                ed = qd.pop_front();
                ec = qc.pop_front();
                check(int'(out_data) == ed, "R3/R4/R5/R6 data", int'(out_data), ed);
                check(int'(out_comp) == ec, "R7 tag", int'(out_comp), ec);
                mcount++;
                if (mcount == mtotal) mdone = 1'b1;
            end
            if (in_valid && in_ready) begin
                if (mdone) movr = 1'b1;
                else begin
                    for (int s = 0; s < ((cfg_fmt == 2'd2) ? 2 : 1); s++) begin
                        qd.push_back(slot_val(int'(cfg_fmt), in_data, s));
                        qc.push_back(tag_of(int'(cfg_arr), mpushed));
                        mpushed++;
                    end
                end
            end
            if (start) begin
                qd.delete();
                qc.delete();
                mcount = 0;
                mpushed = 0;
                mdone = 1'b0;
                movr = 1'b0;
                mtotal = int'(cfg_width) * int'(cfg_height) * ((cfg_arr == 2'd2) ? 2 : 1);
            end
        end
    end

    // Downstream ready pattern.
    always @(posedge clk) begin
        #2;
        case (rdy_mode)
            0: out_ready = 1'b1;
            1: out_ready = ~out_ready;
            2: out_ready = ($urandom % 3) != 0;
            default: out_ready = 1'b0;
        endcase
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            summary();
        end
    end

    task automatic begin_tile(int fmt, int arr, int w, int h);
        @(posedge clk); #2;
        cfg_fmt = 2'(fmt);
        cfg_arr = 2'(arr);
        cfg_width = 9'(w);
        cfg_height = 9'(h);
        start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
    endtask

    task automatic send(logic [15:0] w);
        bit acc;
        acc = 1'b0;
        in_valid = 1'b1;
        in_data = w;
        while (!acc) begin
            @(negedge clk);
            acc = in_ready;
            @(posedge clk); #2;
        end
        in_valid = 1'b0;
        in_data = $urandom;
    endtask

    task automatic wait_done();
        bit d;
        d = 1'b0;
        while (!d) begin
            @(negedge clk);
            d = done;
        end
        @(posedge clk); #2;
    endtask

    task automatic run_tile(int fmt, int arr, int w, int h, int rmode);
        int words;
        rdy_mode = rmode;
        begin_tile(fmt, arr, w, h);
        words = w * h * ((arr == 2) ? 2 : 1) / ((fmt == 2) ? 2 : 1);
        for (int i = 0; i < words; i++) send(16'($urandom));
        wait_done();
        rdy_mode = 0;
    endtask

    initial begin
        in_valid = 1'b1;
        in_data = 16'hBEEF;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: idle until start, words refused.
        check(in_ready == 1'b0, "R1 in_ready", int'(in_ready), 0);
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(done == 1'b0, "R1 done", int'(done), 0);
        check(overrun == 1'b0, "R1 overrun", int'(overrun), 0);
        @(posedge clk); #2;
        in_valid = 1'b0;
        mon_en = 1'b1;

        // R2: in_ready opens one cycle after start.
        begin_tile(0, 0, 8, 8);
        @(negedge clk);
        check(in_ready == 1'b1, "R2 in_ready after start", int'(in_ready), 1);
        @(posedge clk); #2;
        // R8: forced stall with a component held.
        rdy_mode = 3;
        @(posedge clk); #2;
        send(16'hFC2A);
        @(negedge clk);
        begin
            int held;
            held = int'(out_data);
            check(held == 16'hFC2A % 1024, "R3 upper bits ignored", held, 16'hFC2A % 1024);
            repeat (4) @(negedge clk);
            check(out_valid == 1'b1, "R8 valid held", int'(out_valid), 1);
            check(int'(out_data) == held, "R8 data held", int'(out_data), held);
        end
        @(posedge clk); #2;
        rdy_mode = 0;
        for (int i = 1; i < 64; i++) send(16'($urandom));
        wait_done();

        run_tile(1, 0, 8, 8, 1);   // R4
        run_tile(3, 0, 8, 8, 2);   // R5
        run_tile(2, 0, 8, 8, 2);   // R6 single packed
        run_tile(1, 1, 8, 8, 0);   // R7 chroma unpacked
        run_tile(2, 1, 8, 8, 1);   // R6 R7 chroma packed
        run_tile(0, 2, 8, 8, 2);   // R7 three-component unpacked
        run_tile(2, 2, 8, 8, 2);   // R6 R7 three-component packed
        run_tile(3, 2, 10, 8, 1);  // R9 other size

        // R10: surplus words after done.
        send(16'h1234);
        send(16'h5678);
        @(negedge clk);
        check(overrun == 1'b1, "R10 overrun set", int'(overrun), 1);
        check(out_valid == 1'b0, "R10 surplus not emitted", int'(out_valid), 0);
        @(posedge clk); #2;
        begin_tile(2, 1, 8, 8);
        @(negedge clk);
        check(overrun == 1'b0, "R2 overrun cleared", int'(overrun), 0);
        check(done == 1'b0, "R2 done cleared", int'(done), 0);
        @(posedge clk); #2;
        for (int i = 0; i < 32; i++) send(16'($urandom));
        wait_done();

        repeat (5) @(posedge clk);
        summary();
    end

endmodule